// File: doc/BRIEF.md
# Three-Output PWM Timer with Shared Period

This block is a single timer channel. One free-running up-counter drives three pulse-width outputs. The outputs share one period value, and each output has its own duty value. The counter advances on a counter clock. That clock is the system clock passed through two cascaded dividers, or it is an external input, synchronised inside the block, that advances the counter on a chosen edge.

Software programs the channel through a small word-wide register port. The port holds the control word, the first-stage divide value, the three duty values, the period value, the interrupt enables, a sticky event status word and a read-only view of the counter. Each output rises when the counter matches the period value and falls when the counter matches that output's own duty value. Every match event sets a status flag. Any flag that is also enabled raises the interrupt line.

Top module: `pwm3_timer`

## Requirements
- R1: After reset the counter reads 0, every register including status reads 0, all PWM outputs are 0 and the interrupt line is 0.
- R2: The counter advances by one per counter clock only while the run bit (control bit 0, address 0) is 1. While the run bit is 0 the counter holds its value.
- R3: When a counter clock arrives while the counter equals the period value (address 5), the counter goes to 0 instead of incrementing. With a period value P it therefore counts 0..P, and the count read back never exceeds P.
- R4: While the mode bit (control bit 1) is 1, an output is set to 1 on the counter clock at which the counter equals the period value, and cleared to 0 on the counter clock at which it equals its own duty value. Duty A, B and C sit at addresses 2, 3 and 4 and drive outputs 0, 1 and 2. With 0 < D < P, the output is high for D+1 of every P+1 counter clocks.
- R5: A duty value of 0 keeps its output at 0. A duty value equal to the period value also keeps it at 0, because the clear wins over the set on the same count. A duty value above the period value keeps the output at 1 after the first period match.
- R6: With control bits [3:2] = 0, 1 or 2, the counter clock is one pulse every (N+1)·1, (N+1)·2 or (N+1)·4 system clocks. N is the first-stage value at address 1.
- R7: With control bits [3:2] = 3, the counter advances on edges of the external clock input after a two-flop synchronizer. Control bits [5:4] pick the edge: 0 rising, 1 falling, 2 or 3 both.
- R8: Writes to addresses 2 to 5 take effect only while the mode bit is 1. While the mode bit is 0, all PWM outputs stay 0.
- R9: Status (address 7) bits [2:0] record duty matches of A, B and C, and bit [3] records a period match. Each bit is set on a counter clock with that match and stays set until software writes 1 to it. Writing 0 leaves it unchanged.
- R10: The interrupt line is 1 exactly when some status bit is 1 and the matching enable bit at address 6 (same bit layout) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register address for read and write |
| wdata | input | W (16) | Write data |
| rdata | output | W (16) | Read data for `addr`, combinational |
| ext_clk | input | 1 | External counter clock, asynchronous |
| pwm_o | output | N_OUT (3) | PWM outputs A, B, C |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software does not lower the period value below the current count while the counter runs, because the counter would then pass the period and wrap through the full range. The bench always writes the period value and the duty values while the run bit is 0, either straight after reset or after stopping the counter. The assertions also assume that the external clock input stays stable for several system clocks between edges. The bench holds each level of that input for four system clocks, so every edge passes the synchronizer exactly once.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    typedef enum logic [1:0] {
        CS_DIV1 = 2'd0,
        CS_DIV2 = 2'd1,
        CS_DIV4 = 2'd2,
        CS_EXT  = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        EG_RISE  = 2'd0,
        EG_FALL  = 2'd1,
        EG_BOTH  = 2'd2,
        EG_BOTHX = 2'd3
    } edge_pick_e;

    typedef struct packed {
        edge_pick_e edge_sel;
        clk_src_e   src;
        logic       pwm_en;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W  = 6;
    localparam int A_CTRL  = 0;
    localparam int A_PSC   = 1;
    localparam int A_DUTY0 = 2;

    function automatic logic edge_hit(edge_pick_e s, logic rise, logic fall);
        case (s)
            EG_RISE: return rise;
            EG_FALL: return fall;
            default: return rise | fall;
        endcase
    endfunction

    function automatic logic stage2_pass(clk_src_e s, logic [1:0] c);
        case (s)
            CS_DIV1: return 1'b1;
            CS_DIV2: return c[0];
            CS_DIV4: return &c;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pwm3_clkgen.sv
module pwm3_clkgen
    import pwm3_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  clk_src_e         src,
    input  edge_pick_e       edge_sel,
    input  logic [PSC_W-1:0] psc,
    input  logic             ext_in,
    output logic             tick
);
    logic [2:0]       ext_sh;
    logic [PSC_W-1:0] ps_cnt;
    logic [1:0]       s2_cnt;
    logic             p1, rise, fall, int_tick;

    always_ff @(posedge clk) begin
        if (rst) ext_sh <= '0;
        else     ext_sh <= {ext_sh[1:0], ext_in};
    end

    assign rise = ext_sh[1] & ~ext_sh[2];
    assign fall = ~ext_sh[1] & ext_sh[2];

    assign p1 = run && (ps_cnt == psc);

    always_ff @(posedge clk) begin
        if (rst || !run)       ps_cnt <= '0;
        else if (ps_cnt == psc) ps_cnt <= '0;
        else                   ps_cnt <= ps_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) s2_cnt <= '0;
        else if (p1)     s2_cnt <= s2_cnt + 2'd1;
    end

    assign int_tick = p1 && stage2_pass(src, s2_cnt);
    assign tick     = run && ((src == CS_EXT) ? edge_hit(edge_sel, rise, fall) : int_tick);

endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cycle,
    output logic [W-1:0] cnt,
    output logic         at_cycle
);
    assign at_cycle = (cnt == cycle);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= at_cycle ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/pwm3_compare.sv
module pwm3_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         pwm_en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty,
    input  logic         at_cycle,
    output logic         pwm_o,
    output logic         duty_hit
);
    assign duty_hit = (cnt == duty);

    always_ff @(posedge clk) begin
        if (rst || !pwm_en) pwm_o <= 1'b0;
        else if (tick) begin
            if (duty_hit || duty == '0) pwm_o <= 1'b0;
            else if (at_cycle)          pwm_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int W     = 16,
    parameter int PSC_W = 8,
    parameter int N_OUT = 3,
    parameter int AW    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [W-1:0]            wdata,
    output logic [W-1:0]            rdata,
    input  logic [W-1:0]            cnt,
    input  logic                    tick,
    input  logic [N_OUT-1:0]        duty_hit,
    input  logic                    at_cycle,
    output ctrl_t                   ctrl,
    output logic [PSC_W-1:0]        psc,
    output logic [N_OUT-1:0][W-1:0] duty,
    output logic [W-1:0]            cycle,
    output logic [N_OUT:0]          irq_en,
    output logic [N_OUT:0]          flags,
    output logic                    irq
);
    localparam int A_CYC  = A_DUTY0 + N_OUT;
    localparam int A_IEN  = A_CYC + 1;
    localparam int A_STAT = A_CYC + 2;
    localparam int A_CNT  = A_CYC + 3;
    localparam int ST_W   = N_OUT + 1;

    logic [ST_W-1:0] clr, hit;

    assign clr = (wr_en && addr == AW'(A_STAT)) ? wdata[ST_W-1:0] : '0;
    assign hit = tick ? {at_cycle, duty_hit} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            psc    <= '0;
            irq_en <= '0;
            flags  <= '0;
        end else begin
            flags <= (flags & ~clr) | hit;
            if (wr_en && addr == AW'(A_CTRL)) ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_en && addr == AW'(A_PSC))  psc    <= wdata[PSC_W-1:0];
            if (wr_en && addr == AW'(A_IEN))  irq_en <= wdata[ST_W-1:0];
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst) duty[i] <= '0;
            else if (wr_en && ctrl.pwm_en && addr == AW'(A_DUTY0 + i)) duty[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cycle <= '0;
        else if (wr_en && ctrl.pwm_en && addr == AW'(A_CYC)) cycle <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_CTRL))      rdata = W'(ctrl);
        else if (addr == AW'(A_PSC))  rdata = W'(psc);
        else if (addr == AW'(A_CYC))  rdata = cycle;
        else if (addr == AW'(A_IEN))  rdata = W'(irq_en);
        else if (addr == AW'(A_STAT)) rdata = W'(flags);
        else if (addr == AW'(A_CNT))  rdata = cnt;
        for (int i = 0; i < N_OUT; i++)
            if (addr == AW'(A_DUTY0 + i)) rdata = duty[i];
    end

    assign irq = |(flags & irq_en);

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int W     = 16,
    parameter int PSC_W = 8,
    parameter int N_OUT = 3,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    input  logic             ext_clk,
    output logic [N_OUT-1:0] pwm_o,
    output logic             irq
);
    ctrl_t                   ctrl;
    logic [PSC_W-1:0]        psc;
    logic [N_OUT-1:0][W-1:0] duty;
    logic [W-1:0]            cycle, cnt;
    logic [N_OUT:0]          irq_en, flags;
    logic [N_OUT-1:0]        duty_hit;
    logic                    tick, at_cycle;

    pwm3_regs #(.W(W), .PSC_W(PSC_W), .N_OUT(N_OUT), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt(cnt), .tick(tick), .duty_hit(duty_hit),
        .at_cycle(at_cycle), .ctrl(ctrl), .psc(psc), .duty(duty),
        .cycle(cycle), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    pwm3_clkgen #(.PSC_W(PSC_W)) u_clk (
        .clk(clk), .rst(rst), .run(ctrl.run), .src(ctrl.src),
        .edge_sel(ctrl.edge_sel), .psc(psc), .ext_in(ext_clk), .tick(tick)
    );

    pwm3_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cycle(cycle),
        .cnt(cnt), .at_cycle(at_cycle)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        pwm3_compare #(.W(W)) u_cmp (
            .clk(clk), .rst(rst), .tick(tick), .pwm_en(ctrl.pwm_en),
            .cnt(cnt), .duty(duty[i]), .at_cycle(at_cycle),
            .pwm_o(pwm_o[i]), .duty_hit(duty_hit[i])
        );
    end

endmodule

// File: rtl/pwm3_checker.sv
module pwm3_checker
    import pwm3_pkg::*;
#(
    parameter int W     = 16,
    parameter int N_OUT = 3,
    parameter int AW    = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input ctrl_t                   ctrl,
    input logic [W-1:0]            cnt,
    input logic [W-1:0]            cycle,
    input logic [N_OUT-1:0][W-1:0] duty,
    input logic [N_OUT-1:0]        pwm_o,
    input logic [N_OUT:0]          flags,
    input logic                    irq,
    input logic                    wr_en,
    input logic [AW-1:0]           addr,
    input logic [W-1:0]            wdata
);
    localparam int A_STAT = A_DUTY0 + N_OUT + 2;

    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tick && cnt == cycle |=> cnt == '0);  // R3
    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        tick && cnt != cycle |=> cnt == $past(cnt) + W'(1));  // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> $stable(cnt));  // R2
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl.pwm_en |=> pwm_o == '0);  // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        flags == '0 |-> !irq);  // R10

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
            tick && ctrl.pwm_en && (cnt == duty[i] || duty[i] == '0) |=> !pwm_o[i]);  // R5
        AST_SET_AT_CYCLE: assert property (@(posedge clk) disable iff (rst)
            tick && ctrl.pwm_en && cnt == cycle && cnt != duty[i] && duty[i] != '0
            |=> pwm_o[i]);  // R4
    end

    for (genvar j = 0; j <= N_OUT; j++) begin : g_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            flags[j] && !(wr_en && addr == AW'(A_STAT) && wdata[j]) |=> flags[j]);  // R9
    end

endmodule

bind pwm3_timer pwm3_checker #(.W(W), .N_OUT(N_OUT), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl), .cnt(cnt),
    .cycle(cycle), .duty(duty), .pwm_o(pwm_o), .flags(flags), .irq(irq),
    .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/sim_pwm3_timer.sv
module sim_pwm3_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ext_clk = 1'b0;
    logic [2:0]  pwm_o;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int hc [3];

    pwm3_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .pwm_o(pwm_o), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; ext_clk = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[3:0]; wdata = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = a[3:0];
        #1;
        d = int'(rdata);
    endtask

    task automatic count_high(input int n);
        for (int k = 0; k < 3; k++) hc[k] = 0;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) hc[k] += int'(pwm_o[k]);
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(8, v); check("R1 count", v, 0);
        rd(7, v); check("R1 status", v, 0);
        rd(5, v); check("R1 period", v, 0);
        check("R1 outputs", int'(pwm_o), 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_pwm(input int p, input int da, input int db, input int dc,
                         input int ea, input int eb, input int ec, input string tag);
        do_reset();
        wr(0, 2);
        wr(2, da); wr(3, db); wr(4, dc); wr(5, p);
        wr(0, 3);
        repeat (3 * (p + 1)) @(negedge clk);
        count_high(3 * (p + 1));
        check({tag, " out A"}, hc[0], ea);
        check({tag, " out B"}, hc[1], eb);
        check({tag, " out C"}, hc[2], ec);
    endtask

    task automatic t_reload_hold();
        int v, prev, bad_wrap, bad_max, a, b;
        do_reset();
        wr(0, 2); wr(5, 9); wr(0, 3);
        prev = -1; bad_wrap = 0; bad_max = 0;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            rd(8, v);
            if (prev == 9 && v != 0) bad_wrap++;
            if (prev >= 0 && prev != 9 && v != prev + 1) bad_wrap++;
            if (v > 9) bad_max++;
            prev = v;
        end
        check("R3 wraps to 0 after period, steps by 1", bad_wrap, 0);
        check("R3 never above period", bad_max, 0);
        wr(0, 2);
        rd(8, a);
        repeat (20) @(negedge clk);
        rd(8, b);
        check("R2 holds when stopped", b, a);
    endtask

    task automatic t_presc(input int p, input int sel, input int win, input int exp);
        int a, b;
        do_reset();
        wr(0, 2 | (sel << 2)); wr(5, 16'hFFFF); wr(1, p);
        wr(0, 3 | (sel << 2));
        repeat (5) @(negedge clk);
        rd(8, a);
        repeat (win) @(negedge clk);
        rd(8, b);
        check("R6 prescaled ticks", b - a, exp);
    endtask

    task automatic t_ext(input int eg, input int exp);
        int a, b;
        do_reset();
        wr(0, 2 | (3 << 2)); wr(5, 16'hFFFF);
        wr(0, 3 | (3 << 2) | (eg << 4));
        repeat (5) @(negedge clk);
        rd(8, a);
        for (int c = 0; c < 5; c++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(8, b);
        check("R7 external edges counted", b - a, exp);
    endtask

    task automatic t_mode();
        int v;
        do_reset();
        wr(2, 16'h55); rd(2, v);
        check("R8 duty write ignored with mode off", v, 0);
        wr(5, 7); rd(5, v);
        check("R8 period write ignored with mode off", v, 0);
        wr(0, 2); wr(2, 16'h55); rd(2, v);
        check("R8 duty write taken with mode on", v, 16'h55);
        wr(2, 3); wr(5, 9);
        wr(0, 1);
        count_high(30);
        check("R8 outputs low with mode off", hc[0] + hc[1] + hc[2], 0);
    endtask

    task automatic t_irq();
        int v;
        do_reset();
        wr(0, 2); wr(2, 2); wr(5, 4);
        wr(0, 3);
        repeat (20) @(negedge clk);
        wr(0, 2);
        rd(7, v); check("R9 all match flags set", v, 15);
        check("R10 irq low with no enables", int'(irq), 0);
        wr(7, 0); rd(7, v); check("R9 writing 0 keeps flags", v, 15);
        wr(6, 8); #1; check("R10 irq on enabled period flag", int'(irq), 1);
        wr(7, 8); rd(7, v); check("R9 write-1 clears period flag", v, 7);
        #1; check("R10 irq low after clear", int'(irq), 0);
        wr(6, 1); #1; check("R10 irq on enabled duty A flag", int'(irq), 1);
        wr(7, 15); rd(7, v); check("R9 all flags cleared", v, 0);
        #1; check("R10 irq low after full clear", int'(irq), 0);
    endtask

    initial begin
        t_reset();
        t_pwm(9, 3, 0, 12, 12, 0, 30, "R4 R5 mix");
        t_pwm(9, 9, 5, 1, 0, 18, 6, "R4 R5 equal-period");
        t_pwm(5, 2, 4, 6, 9, 15, 18, "R4 R5 short period");
        t_reload_hold();
        t_presc(4, 0, 50, 10);
        t_presc(2, 1, 60, 10);
        t_presc(1, 2, 64, 8);
        t_ext(0, 5);
        t_ext(1, 5);
        t_ext(2, 10);
        t_mode();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule